// File: doc/BRIEF.md
# Integer ALU with Shared-Subtractor Compares

This block is the combinational arithmetic and logic unit of a simple 32-bit integer datapath. It takes two operands and a 4-bit operation code, and in the same cycle it returns a 32-bit result. It also drives a flag that marks an all-zero result and a flag that reports operand equality. It can add, subtract, apply the bitwise XOR, AND and OR functions, shift in three ways, and set a result from a signed or an unsigned less-than test.

A single adder serves every arithmetic and compare function. For every code except add, the adder works as a subtractor that forms A + ~B + 1. The signed less-than flag, the unsigned less-than flag and the equality flag are all taken from that one subtraction, so the block has no separate magnitude comparator. Overflow and carry are used only inside the block and are not brought out. A bitwise NOT is obtained by applying XOR with an all-ones operand.

The block holds no state. It sits between the register-read stage and the write-back mux of a pipeline. The caller supplies the operation code that its decoder has already chosen.

Top module: `int_alu`

## Requirements
- R1: Code 0000 gives A + B modulo 2^32. The same result serves signed and unsigned operands.
- R2: Code 1000 gives A - B modulo 2^32.
- R3: Code 0100 gives A XOR B, code 0110 gives A OR B and code 0111 gives A AND B. XOR with B = FFFFFFFF gives the bitwise NOT of A.
- R4: Code 0001 shifts A left and fills with zeros. Code 0101 shifts A right and fills with zeros. Code 1101 shifts A right and fills with copies of A[31]. The shift amount is B[4:0], and B[31:5] has no effect on the result.
- R5: Code 0010 gives 1 when A < B as two's complement numbers and gives 0 otherwise. The value is zero-extended to 32 bits. The result is correct even when A - B overflows.
- R6: Code 0011 gives 1 when A < B as unsigned numbers and gives 0 otherwise. The value is zero-extended to 32 bits.
- R7: zero_o is 1 exactly when res_o is all zeros, for every code.
- R8: For every code other than 0000, eq_o is 1 exactly when A equals B. For code 0000, eq_o is 0.
- R9: Any code not listed in R1 to R6 gives res_o = 0, and therefore gives zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; its low 5 bits are the shift amount |
| res_o | output | 32 | Result of the selected operation |
| zero_o | output | 1 | res_o is all zeros |
| eq_o | output | 1 | A equals B, taken from the shared subtraction |

## Verification
Every code from 0 to 15 is applied to a grid of corner operands: 0, 1, -1, -2, the largest positive value and the most negative value. This grid separates the signed compare from the unsigned compare. It also exposes an overflow that is handled wrongly when the most negative value is the subtrahend, and it shows whether a right shift fills with zeros or with the sign bit. The same codes then run over pseudo-random operand pairs, where B often has its upper bits set and its low bits cover every shift amount. This checks that only B[4:0] steers the shifter. Equal operands and an explicit all-ones XOR separate the equality and NOT behaviour from ordinary data patterns.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes and widths of the integer ALU.
// Assumes the decoder upstream produces exactly these code values.
package int_alu_pkg;
    localparam int unsigned ALU_W  = 32;
    localparam int unsigned ALU_SW = $clog2(ALU_W);

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b1000,
        OP_SLL  = 4'b0001,
        OP_SLT  = 4'b0010,
        OP_SLTU = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_SRL  = 4'b0101,
        OP_SRA  = 4'b1101,
        OP_OR   = 4'b0110,
        OP_AND  = 4'b0111
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder/subtractor. It forms a + (b ^ {sub}) + sub and returns
// the difference flags that the compares need: the signed less-than, the
// unsigned less-than and an all-zero sum.
// Assumes sub is 1 whenever a compare result is consumed.
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         lt_s_o,
    output logic         lt_u_o,
    output logic         sum_zero_o
);
    logic [W-1:0] b_eff;
    logic         carry;
    logic         ovf;

    // Conditionally invert B, then add with the carry-in equal to sub.
    always_comb begin
        b_eff          = b_i ^ {W{sub_i}};
        {carry, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    end

    // Derive the overflow and both less-than flags from the single sum.
    // The overflow test uses the inverted B before the +1 is added, which
    // stays correct when B is the most negative value.
    always_comb begin
        ovf        = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
        lt_s_o     = sum_o[W-1] ^ ovf;
        lt_u_o     = sub_i ^ carry;
        sum_zero_o = ~|sum_o;
    end

    // Check the subtract mode against the native difference (R2).
    always_comb begin
        if (sub_i) begin
            a_r2_difference: assert (sum_o == a_i - b_i)
                else $error("a_r2_difference: subtract result wrong");
        end
    end
endmodule

// File: rtl/alu_shift.sv
// Module: logarithmic barrel shifter. A left shift reverses the bit order,
// shifts right and reverses back, so one right-shifting network does all
// three shift kinds.
// Assumes amt_i has already been cut to log2(W) bits.
module alu_shift #(
    parameter int unsigned W  = 32,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [0:SW];
    logic         fill;
    logic [W-1:0] net_out;

    // Reverse the input for a left shift and choose the fill bit.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            stage[0][i] = left_i ? data_i[W-1-i] : data_i[i];
        end
        fill = arith_i & ~left_i & data_i[W-1];
    end

    // Each stage shifts right by 2^k when bit k of the amount is set.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        always_comb begin
            stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
        end
    end

    // Undo the reversal for a left shift.
    always_comb begin
        net_out = stage[SW];
        for (int i = 0; i < W; i++) begin
            data_o[i] = left_i ? net_out[W-1-i] : net_out[i];
        end
    end

    // Check a right shift with no fill against the native operator (R4).
    always_comb begin
        if (!left_i && !arith_i) begin
            a_r4_logical_right: assert (data_o == (data_i >> amt_i))
                else $error("a_r4_logical_right: shift result wrong");
        end
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise unit for XOR, OR and AND, selected by a 2-bit code.
// Assumes sel_i is 00 for XOR, 10 for OR and 11 for AND; 01 gives zero.
module alu_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] y_o
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel_i)
            2'b00:   y_o = a_i ^ b_i;
            2'b10:   y_o = a_i | b_i;
            2'b11:   y_o = a_i & b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
// Module: top of the combinational integer ALU. It routes the operands to
// the shared adder, the shifter and the bitwise unit, then selects the
// result by operation code. All compares come from the shared subtraction.
// Assumes op_i is stable for the whole cycle in which the result is used.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned W  = ALU_W,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         eq_o
);
    logic         sub_mode;
    logic [W-1:0] sum;
    logic         lt_s;
    logic         lt_u;
    logic         sum_zero;
    logic [W-1:0] shifted;
    logic [W-1:0] bitwise;
    logic         shl;
    logic         sha;

    // The adder adds only for the add code; every other code subtracts.
    always_comb begin
        sub_mode = (op_i != OP_ADD);
        shl      = (op_i == OP_SLL);
        sha      = (op_i == OP_SRA);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a_i        (a_i),
        .b_i        (b_i),
        .sub_i      (sub_mode),
        .sum_o      (sum),
        .lt_s_o     (lt_s),
        .lt_u_o     (lt_u),
        .sum_zero_o (sum_zero)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .data_i  (a_i),
        .amt_i   (b_i[SW-1:0]),
        .left_i  (shl),
        .arith_i (sha),
        .data_o  (shifted)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (op_i[1:0]),
        .y_o   (bitwise)
    );

    // Select the result by operation code; unlisted codes give zero.
    always_comb begin
        case (op_i)
            OP_ADD, OP_SUB:         res_o = sum;
            OP_SLL, OP_SRL, OP_SRA: res_o = shifted;
            OP_SLT:                 res_o = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:                res_o = {{(W-1){1'b0}}, lt_u};
            OP_XOR, OP_OR, OP_AND:  res_o = bitwise;
            default:                res_o = '0;
        endcase
    end

    // Drive the flags: zero follows the result, equality follows the subtraction.
    always_comb begin
        zero_o = ~|res_o;
        eq_o   = sub_mode & sum_zero;
    end

    // Check the compares and flags against the native operators.
    always_comb begin
        if (op_i == OP_SLT) begin
            a_r5_signed_lt: assert (res_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                else $error("a_r5_signed_lt: signed compare wrong");
        end
        if (op_i == OP_SLTU) begin
            a_r6_unsigned_lt: assert (res_o == {{(W-1){1'b0}}, (a_i < b_i)})
                else $error("a_r6_unsigned_lt: unsigned compare wrong");
        end
        a_r7_zero_flag: assert (zero_o == (res_o == '0))
            else $error("a_r7_zero_flag: zero flag wrong");
        if (sub_mode) begin
            a_r8_equal: assert (eq_o == (a_i == b_i))
                else $error("a_r8_equal: equality flag wrong");
        end
        if (op_i[3] && op_i != OP_SUB && op_i != OP_SRA) begin
            a_r9_unused_zero: assert (res_o == '0)
                else $error("a_r9_unused_zero: unused code not zero");
        end
    end
endmodule

// File: tb/sim_int_alu.sv
// Bench: drives operand/code vectors and compares every output on each clock
// with a behavioural model written using integer arithmetic.
module sim_int_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        zero;
    logic        eq;

    int total;
    int bad;
    bit finished;

    int_alu u0 (
        .op_i   (op),
        .a_i    (a),
        .b_i    (b),
        .res_o  (res),
        .zero_o (zero),
        .eq_o   (eq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model of the result.
    function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        longint sx;
        longint sy;
        int     sh;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        sh = int'(y % 32);
        case (c)
            4'b0000: return 32'(longint'(x) + longint'(y));
            4'b1000: return 32'(longint'(x) - longint'(y));
            4'b0001: return x << sh;
            4'b0010: return (sx < sy) ? 32'd1 : 32'd0;
            4'b0011: return (longint'(x) < longint'(y)) ? 32'd1 : 32'd0;
            4'b0100: return x ^ y;
            4'b0101: return x >> sh;
            4'b1101: return 32'(sx >>> sh);
            4'b0110: return x | y;
            4'b0111: return x & y;
            default: return 32'd0;
        endcase
    endfunction

    // Name the requirement that a code belongs to.
    function automatic string req_tag(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b1000: return "R2";
            4'b0100, 4'b0110, 4'b0111: return "R3";
            4'b0001, 4'b0101, 4'b1101: return "R4";
            4'b0010: return "R5";
            4'b0011: return "R6";
            default: return "R9";
        endcase
    endfunction

    // Apply one vector on the rising edge; check all outputs on the falling edge.
    task automatic run(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] exp_res;
        logic        exp_eq;
        @(posedge clk);
        op = c; a = x; b = y;
        @(negedge clk);
        exp_res = model(c, x, y);
        exp_eq  = (c != 4'b0000) && (x == y);
        total++;
        if (res !== exp_res) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h res actual=%h expected=%h", req_tag(c), c, x, y, res, exp_res);
        end
        total++;
        if (zero !== (exp_res == 32'd0)) begin
            bad++;
            $display("FAIL R7 op=%b a=%h b=%h zero actual=%b expected=%b", c, x, y, zero, (exp_res == 32'd0));
        end
        total++;
        if (eq !== exp_eq) begin
            bad++;
            $display("FAIL R8 op=%b a=%h b=%h eq actual=%b expected=%b", c, x, y, eq, exp_eq);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        for (int n = 0; n < WATCHDOG; n++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [6];
        logic [31:0] lfsr;
        logic [31:0] ra;
        logic [31:0] rb;
        total = 0; bad = 0; finished = 1'b0;
        op = 4'b0000; a = '0; b = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: code 0 on zero operands gives a zero result (R1, R7, R8).
        run(4'b0000, 32'd0, 32'd0);
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF; corners[5] = 32'hFFFF_FFFE;
        // Corner grid over every code: overflow in the compares (R5, R6), equality (R8), unused codes (R9).
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run(4'(c), corners[i], corners[j]);
        // NOT via XOR with all ones (R3).
        run(4'b0100, 32'hA5A5_0F0F, 32'hFFFF_FFFF);
        // Shifts by every amount, with upper B bits set (R4).
        for (int s = 0; s < 32; s++) begin
            run(4'b0001, 32'h8765_4321, 32'hFFFF_FFE0 | 32'(s));
            run(4'b0101, 32'h8765_4321, 32'hABCD_E000 | 32'(s));
            run(4'b1101, 32'h8765_4321, 32'h1234_5660 | 32'(s));
        end
        // Pseudo-random operand pairs over every code.
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = (n % 7 == 0) ? ra : lfsr;
            for (int c = 0; c < 16; c++) run(4'(c), ra, rb);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule